// File: doc/BRIEF.md
# Receive DMA Handshake and Packet-End Controller

This block sits between a serial receiver's character FIFO and a DMA engine. It raises a burst request or a single request from the FIFO fill level so the engine can drain received characters. It runs in one of two modes, chosen by `fc_uart`. With `fc_uart` low, the DMA engine counts its own block length, so the block never marks a last transfer. With `fc_uart` high, the block decides where a packet of unknown length ends. The end is the point where the line has been idle for a programmed number of bit times.

Once that idle timeout expires, burst requests stop. Whatever remains in the FIFO is then moved with single transfers, and the final single carries the last indication. The FIFO can be empty at expiry, which happens when the packet length was an exact multiple of the burst size. In that case the block issues one fake single transfer with last. During that transfer it switches the read data path to a programmable dummy byte, and it sets a sticky flag that software can inspect and clear.

The handshake is request/acknowledge. A request stays high while its condition holds. The engine pulses `dma_ack` once the data phase of the final beat of a transaction has completed. The engine must not acknowledge a transfer that was never requested. The FIFO level must reflect each read no later than the cycle after its acknowledge.

Top module: `uart_rxdma_flow`

## Requirements
- R1: `req_burst` is high when `fifo_level` is nonzero and `fifo_level >= burst_size`. The only exception is the packet-ending phase of UART mode (R5, R6), during which `req_burst` is low.
- R2: `req_single` is high whenever `fifo_level` is nonzero, and also during a fake transfer.
- R3: While `fc_uart` is low, `req_last` and `dummy_sel` stay low, and bit ticks never start a packet end.
- R4: In UART mode, the idle timer is armed by a `char_push` and restarts on every later `char_push`. It expires on the `idle_limit`-th `bit_tick` counted after the most recent push. A tick in the same cycle as a push is not counted, and an `idle_limit` of 0 acts like 1.
- R5: If `fifo_level` is nonzero at expiry, the block enters a drain phase. In this phase `req_last` is high exactly when `fifo_level` equals 1. The block returns to idle after `dma_ack` arrives while `req_last` is high, or as soon as the FIFO is empty.
- R6: If `fifo_level` is zero at expiry, the block enters a fake phase. In this phase `req_single`, `req_last` and `dummy_sel` are high and `rd_data` equals `dummy_byte`; outside it, `rd_data` equals `fifo_rdata`. The fake phase ends on the first `dma_ack`.
- R7: `dummy_flag` becomes high in the cycle that follows entry into the fake phase. It stays high until a cycle in which `flag_clr` is high, and a new set in that same cycle takes priority over the clear.
- R8: In UART mode, `bit_tick` pulses have no effect until the first character arrives after reset or after the previous packet end.
- R9: During and directly after reset, `req_last`, `dummy_sel` and `dummy_flag` are low, and the requests follow only the FIFO level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fc_uart | input | 1 | 1: this block ends packets; 0: DMA engine ends them |
| fifo_level | input | LVL_W (7) | Current receive FIFO fill level |
| char_push | input | 1 | One-cycle pulse per character written into the FIFO |
| bit_tick | input | 1 | One-cycle pulse per received bit time |
| burst_size | input | BURST_W (8) | Characters per burst transaction |
| idle_limit | input | TMO_W (16) | Idle timeout in bit times |
| dma_ack | input | 1 | Transaction-complete pulse from the DMA engine |
| flag_clr | input | 1 | Software clear of the dummy flag |
| fifo_rdata | input | DATA_W (8) | Head-of-FIFO data |
| dummy_byte | input | DATA_W (8) | Byte returned by a fake transfer |
| req_burst | output | 1 | Burst request |
| req_single | output | 1 | Single request |
| req_last | output | 1 | Last-transfer indication |
| dummy_sel | output | 1 | Read path selects the dummy byte |
| rd_data | output | DATA_W (8) | Data for the DMA read path |
| dummy_flag | output | 1 | Sticky flag: a fake transfer was issued |

## Verification
The requests, `req_last`, `dummy_sel` and `rd_data` are combinational in the FIFO level and the phase. They therefore follow a level change in the same cycle, and the bench drives the level and compares within that same cycle. An idle expiry, a return to idle on `dma_ack`, and a set or clear of `dummy_flag` all act on the clock edge that samples the tick, acknowledge or clear. Their outputs therefore change one cycle after the stimulus is driven. The bench's reference model advances its phase on the same rising edge as the design, and the bench compares every output at the falling edge, half a cycle after both have settled.

// File: rtl/uart_rxdma_pkg.sv
package uart_rxdma_pkg;
  typedef enum logic [1:0] {
    FC_IDLE  = 2'd0,
    FC_WAIT  = 2'd1,
    FC_DRAIN = 2'd2,
    FC_FAKE  = 2'd3
  } fc_state_t;
endpackage

// File: rtl/uart_rxdma_idle_timer.sv
module uart_rxdma_idle_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             char_push,
  input  logic             bit_tick,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);
  localparam int EXT_W = TMO_W + 1;

  logic [TMO_W-1:0] cnt;
  logic [EXT_W-1:0] cnt_inc;

  assign cnt_inc = EXT_W'(cnt) + EXT_W'(1);
  assign expire  = run && bit_tick && !char_push && (cnt_inc >= EXT_W'(limit));

  always_ff @(posedge clk) begin
    if (!rst_n || !run || char_push) begin
      cnt <= '0;
    end else if (bit_tick) begin
      cnt <= expire ? '0 : cnt_inc[TMO_W-1:0];
    end
  end
endmodule

// File: rtl/uart_rxdma_req.sv
module uart_rxdma_req
  import uart_rxdma_pkg::*;
#(
  parameter int LVL_W   = 7,
  parameter int BURST_W = 8,
  parameter int DATA_W  = 8
) (
  input  logic               fc_uart,
  input  fc_state_t          st,
  input  logic [LVL_W-1:0]   fifo_level,
  input  logic [BURST_W-1:0] burst_size,
  input  logic [DATA_W-1:0]  fifo_rdata,
  input  logic [DATA_W-1:0]  dummy_byte,
  output logic               req_burst,
  output logic               req_single,
  output logic               req_last,
  output logic               dummy_sel,
  output logic [DATA_W-1:0]  rd_data
);
  localparam int CMP_W = (LVL_W > BURST_W) ? LVL_W : BURST_W;

  logic has_data, at_burst, ending, fake, drain;

  assign has_data = (fifo_level != '0);
  assign at_burst = CMP_W'(fifo_level) >= CMP_W'(burst_size);
  assign drain    = fc_uart && (st == FC_DRAIN);
  assign fake     = fc_uart && (st == FC_FAKE);
  assign ending   = drain || fake;

  always_comb begin
    req_burst  = has_data && at_burst && !ending;
    req_single = has_data || fake;
    req_last   = fake || (drain && (fifo_level == LVL_W'(1)));
    dummy_sel  = fake;
    rd_data    = fake ? dummy_byte : fifo_rdata;
  end
endmodule

// File: rtl/uart_rxdma_flow.sv
module uart_rxdma_flow
  import uart_rxdma_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int BURST_W    = 8,
  parameter int TMO_W      = 16,
  parameter int DATA_W     = 8,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fc_uart,
  input  logic [LVL_W-1:0]   fifo_level,
  input  logic               char_push,
  input  logic               bit_tick,
  input  logic [BURST_W-1:0] burst_size,
  input  logic [TMO_W-1:0]   idle_limit,
  input  logic               dma_ack,
  input  logic               flag_clr,
  input  logic [DATA_W-1:0]  fifo_rdata,
  input  logic [DATA_W-1:0]  dummy_byte,
  output logic               req_burst,
  output logic               req_single,
  output logic               req_last,
  output logic               dummy_sel,
  output logic [DATA_W-1:0]  rd_data,
  output logic               dummy_flag
);
  fc_state_t st, st_n;
  logic      expire, set_flag, tmr_run;

  assign tmr_run = fc_uart && (st == FC_WAIT);

  uart_rxdma_idle_timer #(.TMO_W(TMO_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (tmr_run),
    .char_push (char_push),
    .bit_tick  (bit_tick),
    .limit     (idle_limit),
    .expire    (expire)
  );

  uart_rxdma_req #(.LVL_W(LVL_W), .BURST_W(BURST_W), .DATA_W(DATA_W)) u_req (
    .fc_uart    (fc_uart),
    .st         (st),
    .fifo_level (fifo_level),
    .burst_size (burst_size),
    .fifo_rdata (fifo_rdata),
    .dummy_byte (dummy_byte),
    .req_burst  (req_burst),
    .req_single (req_single),
    .req_last   (req_last),
    .dummy_sel  (dummy_sel),
    .rd_data    (rd_data)
  );

  always_comb begin
    st_n     = st;
    set_flag = 1'b0;
    if (!fc_uart) begin
      st_n = FC_IDLE;
    end else begin
      unique case (st)
        FC_IDLE:  if (char_push) st_n = FC_WAIT;
        FC_WAIT:  if (expire) begin
                    if (fifo_level == '0) begin
                      st_n     = FC_FAKE;
                      set_flag = 1'b1;
                    end else begin
                      st_n = FC_DRAIN;
                    end
                  end
        FC_DRAIN: if ((dma_ack && req_last) || (fifo_level == '0)) st_n = FC_IDLE;
        FC_FAKE:  if (dma_ack) st_n = FC_IDLE;
        default:  st_n = FC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= FC_IDLE;
      dummy_flag <= 1'b0;
    end else begin
      st <= st_n;
      if (set_flag)      dummy_flag <= 1'b1;
      else if (flag_clr) dummy_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rxdma_checker.sv
module uart_rxdma_checker #(
  parameter int LVL_W  = 7,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fc_uart,
  input logic [LVL_W-1:0]  fifo_level,
  input logic              flag_clr,
  input logic              req_burst,
  input logic              req_single,
  input logic              req_last,
  input logic              dummy_sel,
  input logic              dummy_flag
);
  a_r3_no_last_in_ext_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_uart |-> (!req_last && !dummy_sel));

  a_r1_burst_has_single: assert property (@(posedge clk) disable iff (!rst_n)
    req_burst |-> req_single);

  a_r2_single_when_data: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level != '0) |-> req_single);

  a_r5_no_burst_at_last: assert property (@(posedge clk) disable iff (!rst_n)
    req_last |-> !req_burst);

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (dummy_flag && !flag_clr) |=> dummy_flag);

  a_r6_fake_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dummy_sel) |-> dummy_flag);
endmodule

bind uart_rxdma_flow uart_rxdma_checker #(.LVL_W(LVL_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fc_uart    (fc_uart),
  .fifo_level (fifo_level),
  .flag_clr   (flag_clr),
  .req_burst  (req_burst),
  .req_single (req_single),
  .req_last   (req_last),
  .dummy_sel  (dummy_sel),
  .dummy_flag (dummy_flag)
);

// File: tb/tb_uart_rxdma_flow.sv
module tb_uart_rxdma_flow;
  localparam int DEPTH = 64;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n = 1'b0, fc_uart = 1'b0, char_push = 1'b0, bit_tick = 1'b0;
  logic             dma_ack = 1'b0, flag_clr = 1'b0;
  logic [LVL_W-1:0] fifo_level = '0;
  logic [7:0]       burst_size = 8'd4, fifo_rdata = 8'h3C, dummy_byte = 8'hA5, rd_data;
  logic [15:0]      idle_limit = 16'd5;
  logic             req_burst, req_single, req_last, dummy_sel, dummy_flag;

  uart_rxdma_flow dut (
    .clk(clk), .rst_n(rst_n), .fc_uart(fc_uart), .fifo_level(fifo_level),
    .char_push(char_push), .bit_tick(bit_tick), .burst_size(burst_size),
    .idle_limit(idle_limit), .dma_ack(dma_ack), .flag_clr(flag_clr),
    .fifo_rdata(fifo_rdata), .dummy_byte(dummy_byte), .req_burst(req_burst),
    .req_single(req_single), .req_last(req_last), .dummy_sel(dummy_sel),
    .rd_data(rd_data), .dummy_flag(dummy_flag)
  );

  // Reference model: 0 idle, 1 waiting for silence, 2 draining residue, 3 fake transfer
  int    lvl = 0, m_phase = 0, m_ticks = 0;
  bit    m_flag = 0;
  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R9";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase <= 0; m_ticks <= 0; m_flag <= 0;
    end else if (!fc_uart) begin
      m_phase <= 0; m_ticks <= 0;
      if (flag_clr) m_flag <= 0;
    end else begin
      if (flag_clr) m_flag <= 0;
      if (m_phase == 0) begin
        if (char_push) begin m_phase <= 1; m_ticks <= 0; end
      end else if (m_phase == 1) begin
        if (char_push) m_ticks <= 0;
        else if (bit_tick) begin
          if (m_ticks + 1 >= int'(idle_limit)) begin
            m_ticks <= 0;
            if (lvl == 0) begin m_phase <= 3; m_flag <= 1; end
            else m_phase <= 2;
          end else m_ticks <= m_ticks + 1;
        end
      end else if (m_phase == 2) begin
        if ((dma_ack && lvl == 1) || lvl == 0) m_phase <= 0;
      end else begin
        if (dma_ack) m_phase <= 0;
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit fake, drain;
    fake  = fc_uart && m_phase == 3;
    drain = fc_uart && m_phase == 2;
    chk("req_burst", int'(req_burst), int'(lvl != 0 && lvl >= int'(burst_size) && !fake && !drain));
    chk("req_single", int'(req_single), int'(lvl != 0 || fake));
    chk("req_last", int'(req_last), int'(fake || (drain && lvl == 1)));
    chk("dummy_sel", int'(dummy_sel), int'(fake));
    chk("rd_data", int'(rd_data), fake ? int'(dummy_byte) : int'(fifo_rdata));
    chk("dummy_flag", int'(dummy_flag), int'(m_flag));
  end

  task automatic cyc(input bit push, input bit tick, input bit ack, input int consume);
    char_push = push; bit_tick = tick; dma_ack = ack;
    @(posedge clk); #1;
    lvl = lvl + int'(push) - consume;
    fifo_level = LVL_W'(lvl);
    char_push = 0; bit_tick = 0; dma_ack = 0; flag_clr = 0;
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cur_req = "R9";
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    cyc(0, 0, 0, 0);
    // external flow control
    cur_req = "R1";
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0);
    cyc(0, 0, 1, 4);
    cur_req = "R2";
    cyc(0, 0, 1, 1);
    cyc(1, 0, 0, 0);
    cyc(0, 0, 1, 1);
    cur_req = "R3";
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
    for (int i = 0; i < 12; i++) cyc(0, 1, 0, 0);
    cyc(0, 0, 1, 2);
    // UART is flow controller
    fc_uart = 1;
    cur_req = "R8";
    for (int i = 0; i < 12; i++) cyc(0, 1, 0, 0);
    cur_req = "R4";
    for (int i = 0; i < 2; i++) cyc(1, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0);
    cyc(1, 1, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0);
    cur_req = "R5";
    cyc(0, 1, 0, 0);
    cyc(0, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 1);
    cyc(0, 0, 0, 0);
    // burst suppressed once packet is ending
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 1);
    cyc(0, 0, 0, 0);
    // exact multiple of burst size: fake last
    cur_req = "R6";
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0);
    cyc(0, 0, 1, 4);
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0);
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    cyc(0, 0, 1, 0);
    cur_req = "R7";
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0);
    flag_clr = 1;
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    // single-tick limit boundary
    cur_req = "R4";
    idle_limit = 16'd1;
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
    cyc(0, 1, 0, 0);
    cur_req = "R5";
    cyc(0, 0, 1, 1); cyc(0, 0, 1, 1);
    cyc(0, 0, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule